// File: doc/BRIEF.md
# Counter with Cross-Clock Edge Preset

This block is a small binary counter that runs in a fast clock domain and advances by one on every rising edge of that clock. A second clock runs slower than the first, and its phase and frequency bear no fixed relation to it. Each falling edge of the slower clock forces the counter to the preset value 7. The counter wraps from its largest value back to zero.

The slow falling edge is recorded in the slow domain as a toggle of a one-bit flag register. That flag crosses into the fast domain through a two-flop synchronizer, and an extra stage after the synchronizer turns each change of the flag into a single-cycle load request. Every flop uses one clock edge, so the whole design synthesizes with ordinary flip-flops. A registered strobe marks the fast cycle in which the preset value appears. When the preset and an ordinary increment land on the same fast edge, the preset wins.

Top module: `xclk_preset_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_fast`, `count` becomes 0 and `preset_done` becomes 0. If `rst` is high across at least one falling edge of `clk_slow`, no preset follows its release until a new falling edge of `clk_slow` arrives.
- R2: Without a preset, `count` rises by exactly one on every rising edge of `clk_fast`. This includes the time while `clk_slow` is held low.
- R3: On an increment, a 4-bit `count` goes from 15 to 0.
- R4: A falling edge of `clk_slow` (with `rst` low) makes `count` equal 7 after the third rising edge of `clk_fast` that follows it in time. With the default two synchronizer stages, that is two to three fast periods later.
- R5: On the fast edge that applies a preset, the result is exactly 7. It is neither 8 nor the old value plus one.
- R6: `preset_done` is high for exactly the one fast cycle in which a preset loaded 7. It stays low at all other times, including when `count` reaches 7 by incrementing.
- R7: A rising edge of `clk_slow` has no effect on `count` or `preset_done`.
- R8: Slow falling edges spaced at least three fast periods apart each produce exactly one preset. Falling edges seen while `rst` is high produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; the counter and synchronizer run on its rising edge |
| clk_slow | input | 1 | Slow clock with no fixed relation to clk_fast; its falling edge requests a preset |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| count | output | 4 | Registered counter value |
| preset_done | output | 1 | Registered strobe, high in the cycle the preset value is loaded |

## Verification
The slow clock is driven with randomized high and low half-periods, so falling edges land at many different phases inside a fast period. Each case tells apart an edge that arrives just before a fast rising edge from one that arrives just after it. Long low phases separate edge-triggered loading from level-triggered loading. Runs of up to twenty-five fast cycles between presets push the count through its wrap. A mid-run reset held across slow falling edges shows whether a flag change caught during reset leaks out as a false preset after release. In every case, the cycle that carries the load shows whether the preset beats the increment and whether the strobe lines up with the loaded value.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  localparam int DEF_WIDTH  = 4;
  localparam int DEF_PRESET = 7;
  localparam int DEF_STAGES = 2;
endpackage

// File: rtl/xpc_edge_flag.sv
// Slow domain: flips a one-bit flag on every falling edge of the slow clock.
module xpc_edge_flag (
  input  logic clk_slow,
  input  logic rst,
  output logic flag
);
  always_ff @(negedge clk_slow) begin
    if (rst) flag <= 1'b0;
    else     flag <= ~flag;
  end
endmodule

// File: rtl/xpc_toggle_sync.sv
// Fast domain: synchronizer chain plus one extra stage; a change between
// the last two stages becomes a one-cycle load request.
module xpc_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst,
  input  logic flag_async,
  output logic load_req
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_fast) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= flag_async;
        end
      end else begin : g_next
        always_ff @(posedge clk_fast) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign load_req = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/xpc_count_core.sv
// Fast domain counter; the load request has priority over the increment.
module xpc_count_core #(
  parameter int WIDTH  = 4,
  parameter int PRESET = 7
) (
  input  logic             clk_fast,
  input  logic             rst,
  input  logic             load_req,
  output logic [WIDTH-1:0] count,
  output logic             preset_done
);
  localparam logic [WIDTH-1:0] LOAD_VAL = WIDTH'(PRESET);
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      count       <= '0;
      preset_done <= 1'b0;
    end else if (load_req) begin
      count       <= LOAD_VAL;
      preset_done <= 1'b1;
    end else begin
      count       <= count + ONE;
      preset_done <= 1'b0;
    end
  end
endmodule

// File: rtl/xclk_preset_counter.sv
module xclk_preset_counter
  import xpc_pkg::*;
#(
  parameter int WIDTH  = DEF_WIDTH,
  parameter int PRESET = DEF_PRESET,
  parameter int STAGES = DEF_STAGES
) (
  input  logic             clk_fast,
  input  logic             clk_slow,
  input  logic             rst,
  output logic [WIDTH-1:0] count,
  output logic             preset_done
);
  logic flag;
  logic load_req;

  xpc_edge_flag u_flag (
    .clk_slow (clk_slow),
    .rst      (rst),
    .flag     (flag)
  );

  xpc_toggle_sync #(.STAGES(STAGES)) u_sync (
    .clk_fast   (clk_fast),
    .rst        (rst),
    .flag_async (flag),
    .load_req   (load_req)
  );

  xpc_count_core #(.WIDTH(WIDTH), .PRESET(PRESET)) u_core (
    .clk_fast    (clk_fast),
    .rst         (rst),
    .load_req    (load_req),
    .count       (count),
    .preset_done (preset_done)
  );
endmodule

// File: rtl/xpc_checker.sv
module xpc_checker #(
  parameter int WIDTH  = 4,
  parameter int PRESET = 7
) (
  input logic             clk_fast,
  input logic             rst,
  input logic [WIDTH-1:0] count,
  input logic             preset_done
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk_fast) if (rst) seen_rst <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk_fast)
    seen_rst && $past(rst) |-> (count == '0) && !preset_done); // R1

  AST_STEP_ONE: assert property (@(posedge clk_fast) disable iff (rst || !seen_rst)
    !$past(rst) && !preset_done |-> count == WIDTH'($past(count) + 1'b1)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk_fast) disable iff (rst || !seen_rst)
    !$past(rst) && !preset_done && ($past(count) == {WIDTH{1'b1}}) |-> count == '0); // R3

  AST_PRESET_VALUE: assert property (@(posedge clk_fast) disable iff (rst || !seen_rst)
    preset_done |-> count == WIDTH'(PRESET)); // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk_fast) disable iff (rst || !seen_rst)
    preset_done |=> !preset_done); // R6
endmodule

bind xclk_preset_counter xpc_checker #(.WIDTH(WIDTH), .PRESET(PRESET)) u_chk (
  .clk_fast    (clk_fast),
  .rst         (rst),
  .count       (count),
  .preset_done (preset_done)
);

// File: tb/sim_xclk_preset_counter.sv
`timescale 1ns/1ps
module sim_xclk_preset_counter;
  logic       clk_fast = 1'b0;
  logic       clk_slow = 1'b1;
  logic       rst = 1'b1;
  logic [3:0] count;
  logic       preset_done;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  // fall/rise records for the model
  int  fall_seq = 0;
  time fall_time = 0;
  time rise_time = 0;

  xclk_preset_counter u0 (
    .clk_fast    (clk_fast),
    .clk_slow    (clk_slow),
    .rst         (rst),
    .count       (count),
    .preset_done (preset_done)
  );

  // 50 MHz: rising edges at 10, 30, 50 ... ns
  always #10 clk_fast = ~clk_fast;

  // slow clock edges at times ending in 5 ns, never on a fast edge
  initial begin
    int seed_use;
    seed_use = $urandom(32'd4242);
    #5;
    forever begin
      int k;
      if (($urandom % 8) == 0) k = 20 + ($urandom % 6);   // long phases
      else                     k = 4 + ($urandom % 10);
      #(10 * k) clk_slow = ~clk_slow;
    end
  end

  always @(negedge clk_slow) begin
    if (!rst) begin
      fall_time = $time;
      fall_seq  = fall_seq + 1;
    end
  end
  always @(posedge clk_slow) rise_time = $time;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int next_val(input int v);
    return (v + 1) % 16;
  endfunction

  initial begin
    int  exp_cnt = 0;
    int  exp_done = 0;
    int  pend = -1;
    int  seen_seq = 0;
    time t_now;
    string tag;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk_fast);
      t_now = $time;
      // model one rising edge (at t_now-10) with rst as it was there
      if (rst) begin
        exp_cnt = 0; exp_done = 0; pend = -1; seen_seq = fall_seq;
      end else begin
        if (fall_seq != seen_seq) begin
          seen_seq = fall_seq;
          pend = (fall_time < t_now - 10) ? 1 : 0;
        end else if (pend >= 0) begin
          pend++;
        end
        if (pend == 3) begin
          exp_cnt = 7; exp_done = 1; pend = -1;
        end else begin
          exp_cnt = next_val(exp_cnt); exp_done = 0;
        end
      end
      if (rst)                           tag = "R1";
      else if (cyc >= 2040 && cyc < 2100) tag = "R8";
      else if (exp_done == 1)            tag = "R4/R5";
      else if (exp_cnt == 0)             tag = "R3";
      else if (rise_time > t_now - 60 && rise_time != 0) tag = "R7";
      else                               tag = "R2";
      chk(tag, "count", int'(count), exp_cnt);
      chk(rst ? "R1" : "R6", "preset_done", int'(preset_done), exp_done);
      // reset schedule, changed only at falling fast edges
      if (cyc == 5)    rst = 1'b0;
      if (cyc == 2000) rst = 1'b1;   // R8: held across slow falling edges
      if (cyc == 2040) rst = 1'b0;
    end
    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule